// File: doc/BRIEF.md
# DAC Output Load-Detect Sequencer

This block runs the load-presence test on the six outputs of a multi-channel current-output DAC. The DAC core has one shared comparator. A 3-bit channel select picks which output the comparator watches. An active-low evaluate strobe starts each comparison on its falling edge. The sequencer drives both signals with the setup, pulse-width and result-delay margins that the comparator needs. It brings the asynchronous comparator result into the clock domain and keeps one presence flag per channel.

A caller first puts the DAC data codes it wants in place; the sequencer does not set them. The caller then issues a one-cycle start. The start carries either a six-bit channel mask or a single channel index. The sequencer visits the requested channels in ascending order. While it works it shows busy. It pulses done once all requested channels are finished. The comparator output has inverted meaning: low says the output voltage is above the threshold, which means nothing is connected. A high comparator result is recorded as "load present". All timing values are counts of system-clock cycles, set by parameters.

Top module: `dac_load_detect_seq`

## Requirements
- R1: After reset, the strobe is high, select is 0, busy and done are low, and all six presence flags are 0.
- R2: In mask mode (`scan_single_i` = 0), bit k of `scan_mask_i` requests channel k. Each requested channel gets exactly one strobe pulse, in ascending channel order. An all-zero mask produces no strobe pulse, but done still pulses.
- R3: In single mode (`scan_single_i` = 1), an index of 0 to 5 requests only that channel. An index of 6 or 7 requests nothing: there is no strobe pulse, but done still pulses. Select only takes values 0 to 5 while busy.
- R4: Select is stable for at least SETUP_CYC cycles before the strobe falls, and it does not change while the strobe is low.
- R5: Each strobe-low period lasts max(PULSE_CYC, VALID_CYC + SYNC_STAGES) cycles, which is never less than PULSE_CYC.
- R6: The flag of an evaluated channel is taken from the synchronised comparator at the end of its low period. Because the synchroniser adds its latency, the value sampled is the one seen at least VALID_CYC cycles after the fall. Comparator high sets the flag to 1 (load present). Comparator low sets it to 0 (no load).
- R7: Flags of channels that were not requested keep their previous values.
- R8: After each strobe rise, the strobe stays high for at least SETUP_CYC cycles before select moves to the next channel.
- R9: Busy is high from the cycle after an accepted start until done. Done is a single-cycle pulse, and busy is already low in that cycle.
- R10: A start that arrives while busy is ignored. It causes no extra pulses, changes no flags and produces no extra done.
- R11: The strobe is high whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start_i | input | 1 | One-cycle start request, accepted only when idle |
| scan_single_i | input | 1 | 1: use the channel index; 0: use the channel mask |
| scan_index_i | input | 3 | Channel index for single mode |
| scan_mask_i | input | 6 | Channel request mask for mask mode |
| det_cmp_i | input | 1 | Asynchronous comparator result (high = load attached) |
| det_sel_o | output | 3 | Channel select to the comparator multiplexer |
| det_strobe_n_o | output | 1 | Active-low evaluate strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| load_present_o | output | 6 | Per-channel load-present flags |

## Verification
Several rules are checked on every cycle by assertions:
- the strobe is high while idle;
- select stays still during a low strobe;
- the low width meets its minimum;
- select stays in range while busy;
- done is a single-cycle pulse with busy low.

Other behaviour only the bench scenarios can show. These are the ascending visiting order, the setup and recovery gaps around each pulse, and the sampling point. The bench checks the sampling point with a comparator model that returns the wrong polarity until the valid delay has passed. The scenarios also cover kept flags of unrequested channels, out-of-range indices and ignored starts.

// File: rtl/dld_pkg.sv
package dld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_SETUP,
    ST_EVAL,
    ST_RECOV
  } dld_state_e;
endpackage

// File: rtl/dld_sync.sv
module dld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dld_timer.sv
module dld_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dld_pick.sv
module dld_pick #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/dac_load_detect_seq.sv
module dac_load_detect_seq
  import dld_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SETUP_CYC   = 5,
  parameter int PULSE_CYC   = 10,
  parameter int VALID_CYC   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start_i,
  input  logic              scan_single_i,
  input  logic [SEL_W-1:0]  scan_index_i,
  input  logic [NUM_CH-1:0] scan_mask_i,
  input  logic              det_cmp_i,
  output logic [SEL_W-1:0]  det_sel_o,
  output logic              det_strobe_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NUM_CH-1:0] load_present_o
);
  localparam int LOW_CYC = (PULSE_CYC > VALID_CYC + SYNC_STAGES) ? PULSE_CYC
                                                                 : VALID_CYC + SYNC_STAGES;
  localparam int MAX_CYC = (LOW_CYC > SETUP_CYC) ? LOW_CYC : SETUP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  dld_state_e        state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              strobe_n_q, strobe_n_d;
  logic [NUM_CH-1:0] flags_q, flags_d;
  logic              done_q, done_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              cmp_sync;
  logic              pick_found;
  logic [SEL_W-1:0]  pick_idx;
  logic [NUM_CH-1:0] req_mask;

  dld_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(det_cmp_i), .q_o(cmp_sync)
  );

  dld_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(tmr_exp)
  );

  dld_pick #(.N(NUM_CH), .IDX_W(SEL_W)) u_pick (
    .pend_i(pend_q), .found_o(pick_found), .idx_o(pick_idx)
  );

  always_comb begin
    req_mask = '0;
    if (scan_single_i) begin
      if (int'(scan_index_i) < NUM_CH) req_mask[scan_index_i] = 1'b1;
    end else begin
      req_mask = scan_mask_i;
    end
  end

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    sel_d      = sel_q;
    strobe_n_d = strobe_n_q;
    flags_d    = flags_q;
    done_d     = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (state_q)
      ST_IDLE: begin
        strobe_n_d = 1'b1;
        if (scan_start_i) begin
          pend_d  = req_mask;
          state_d = ST_PICK;
        end
      end
      ST_PICK: begin
        if (pick_found) begin
          sel_d            = pick_idx;
          pend_d[pick_idx] = 1'b0;
          tmr_load         = 1'b1;
          tmr_val          = CNT_W'(SETUP_CYC - 1);
          state_d          = ST_SETUP;
        end else begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          strobe_n_d = 1'b0;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(LOW_CYC - 1);
          state_d    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (tmr_exp) begin
          strobe_n_d     = 1'b1;
          flags_d[sel_q] = cmp_sync;
          tmr_load       = 1'b1;
          tmr_val        = CNT_W'(SETUP_CYC - 1);
          state_d        = ST_RECOV;
        end
      end
      ST_RECOV: begin
        if (tmr_exp) state_d = ST_PICK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      sel_q      <= '0;
      strobe_n_q <= 1'b1;
      flags_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_q     <= pend_d;
      sel_q      <= sel_d;
      strobe_n_q <= strobe_n_d;
      flags_q    <= flags_d;
      done_q     <= done_d;
    end
  end

  assign det_sel_o      = sel_q;
  assign det_strobe_n_o = strobe_n_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
  assign load_present_o = flags_q;

  // Checking support: strobe-low run length, saturating.
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run_q <= '0;
    else if (det_strobe_n_o)     low_run_q <= '0;
    else if (low_run_q != '1)    low_run_q <= low_run_q + 1'b1;
  end

  assert_idle_strobe_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> det_strobe_n_o);

  assert_sel_stable_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_strobe_n_o && !$past(det_strobe_n_o)) |-> $stable(det_sel_o));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_strobe_n_o) |-> (int'(low_run_q) >= PULSE_CYC));

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(det_sel_o) < NUM_CH));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_dac_load_detect_seq.sv
module tb_dac_load_detect_seq;
  localparam int NCH   = 6;
  localparam int SETUP = 5;
  localparam int PULSE = 10;
  localparam int VALID = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_start_i = 1'b0;
  logic       scan_single_i = 1'b0;
  logic [2:0] scan_index_i = '0;
  logic [5:0] scan_mask_i = '0;
  logic       det_cmp_i = 1'b0;
  logic [2:0] det_sel_o;
  logic       det_strobe_n_o;
  logic       busy_o;
  logic       done_o;
  logic [5:0] load_present_o;

  dac_load_detect_seq dut (
    .clk(clk), .rst_n(rst_n), .scan_start_i(scan_start_i), .scan_single_i(scan_single_i),
    .scan_index_i(scan_index_i), .scan_mask_i(scan_mask_i), .det_cmp_i(det_cmp_i),
    .det_sel_o(det_sel_o), .det_strobe_n_o(det_strobe_n_o), .busy_o(busy_o),
    .done_o(done_o), .load_present_o(load_present_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed { logic [5:0] mask; logic [5:0] flags; } exp_t;
  exp_t       sb_q[$];
  logic [5:0] load_model = '0;
  logic [5:0] flag_model = '0;

  // Monitor and comparator model
  logic       prev_strobe = 1'b1;
  logic       prev_busy = 1'b0;
  logic [2:0] prev_sel = '0;
  int         low_cnt = 0;
  int         high_cnt = 1000;
  int         hold_sel = 1000;
  logic [5:0] exp_rem = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o && !prev_busy) exp_rem = (sb_q.size() > 0) ? sb_q[0].mask : 6'h0;
      if (prev_strobe && !det_strobe_n_o) begin
        int lo;
        lo = -1;
        for (int k = NCH - 1; k >= 0; k--) if (exp_rem[k]) lo = k;
        chk(hold_sel >= SETUP, "R4 select setup before strobe fall", hold_sel, SETUP);
        chk(lo >= 0 && int'(det_sel_o) == lo, "R2 ascending requested channel", det_sel_o, lo);
        if (lo >= 0) exp_rem[lo] = 1'b0;
      end
      if (!det_strobe_n_o && !prev_strobe && det_sel_o != prev_sel)
        chk(1'b0, "R4 select moved while strobe low", det_sel_o, prev_sel);
      if (!prev_strobe && det_strobe_n_o)
        chk(low_cnt >= PULSE, "R5 strobe low width", low_cnt, PULSE);
      if (det_sel_o != prev_sel)
        chk(high_cnt >= SETUP, "R8 recovery before select change", high_cnt, SETUP);
      if (!busy_o)
        chk(det_strobe_n_o, "R11 strobe high when idle", det_strobe_n_o, 1);
      if (done_o) begin
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
        chk(sb_q.size() > 0, "R10 unexpected done", sb_q.size(), 1);
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(load_present_o == e.flags, "R6 R7 presence flags", load_present_o, e.flags);
          chk(exp_rem == 6'h0, "R2 all requested channels visited", exp_rem, 0);
        end
      end
      low_cnt  = det_strobe_n_o ? 0 : low_cnt + 1;
      high_cnt = det_strobe_n_o ? high_cnt + 1 : 0;
      hold_sel = (det_sel_o != prev_sel) ? 1 : hold_sel + 1;
      if (!det_strobe_n_o && low_cnt >= VALID + 1 && int'(det_sel_o) < NCH)
        det_cmp_i <= load_model[det_sel_o];
      else if (int'(det_sel_o) < NCH)
        det_cmp_i <= ~load_model[det_sel_o];
      prev_strobe = det_strobe_n_o;
      prev_busy   = busy_o;
      prev_sel    = det_sel_o;
    end
  end

  task automatic run_req(input bit single, input logic [2:0] idx, input logic [5:0] mask,
                         input logic [5:0] loads, input bit poke);
    logic [5:0] m;
    exp_t e;
    m = single ? ((idx < NCH) ? (6'h1 << idx) : 6'h0) : mask;
    load_model = loads;
    flag_model = (flag_model & ~m) | (loads & m);
    e.mask = m;
    e.flags = flag_model;
    sb_q.push_back(e);
    @(negedge clk);
    scan_start_i = 1'b1; scan_single_i = single; scan_index_i = idx; scan_mask_i = mask;
    @(negedge clk);
    scan_start_i = 1'b0;
    chk(busy_o, "R9 busy after accepted start", busy_o, 1);
    if (poke) begin
      repeat (8) @(negedge clk);
      scan_start_i = 1'b1; scan_single_i = 1'b0; scan_mask_i = 6'h3F;
      @(negedge clk);
      scan_start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(det_strobe_n_o, "R1 reset strobe", det_strobe_n_o, 1);
    chk(det_sel_o == 0, "R1 reset select", det_sel_o, 0);
    chk(!busy_o, "R1 reset busy", busy_o, 0);
    chk(!done_o, "R1 reset done", done_o, 0);
    chk(load_present_o == 0, "R1 reset flags", load_present_o, 0);

    run_req(1'b0, 3'd0, 6'h3F, 6'b101101, 1'b0);  // R2 full scan
    run_req(1'b0, 3'd0, 6'b010010, 6'b010000, 1'b0); // R7 partial scan keeps others
    run_req(1'b1, 3'd5, 6'h00, 6'b000000, 1'b0);  // R3 single channel 5 clears its flag
    run_req(1'b1, 3'd0, 6'h00, 6'b111111, 1'b0);  // R3 single channel 0
    run_req(1'b1, 3'd6, 6'h3F, 6'b111111, 1'b0);  // R3 out-of-range index: nothing
    run_req(1'b1, 3'd7, 6'h3F, 6'b000000, 1'b0);  // R3 out-of-range index: nothing
    run_req(1'b0, 3'd0, 6'h00, 6'b111111, 1'b0);  // R2 empty mask
    run_req(1'b0, 3'd0, 6'b000100, 6'b000100, 1'b1); // R10 start while busy ignored
    repeat (60) @(negedge clk);
    chk(!busy_o, "R10 no extra sequence after ignored start", busy_o, 0);
    chk(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);
    chk(load_present_o == flag_model, "R10 flags after ignored start", load_present_o, flag_model);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule